// File: doc/BRIEF.md
# Mailbox Protocol Discovery Scanner

After reset this block takes control of a data-object mailbox requester. It first resets the mailbox with an abort. It then walks the mailbox's discovery chain. Each step sends a one-dword discovery request that carries an index. The one-dword reply gives a vendor ID, a protocol number and the index of the next entry. The block stores each (vendor ID, protocol) pair in a small table whose size is a parameter. The walk stops when the reply's next index is zero, or when an error occurs.

Once the table is filled, other logic can ask, combinationally, whether a given vendor ID and protocol type are supported. The discovery protocol itself is always reported as supported. An abort failure, a transport error, a reply of the wrong length or a full table stops the scan with an error flag. After an error, every lookup misses except the one for the discovery protocol.

Top module: `mbox_proto_scan`

## Requirements
- R1: While `rst_n` is low, `scan_done`, `scan_err`, `mbox_failed` and `entry_count` are 0. The first request after reset is an abort (`req_valid`=1, `req_abort`=1). A request holds its fields until `req_ready` is sampled high.
- R2: If the abort reply has `rsp_err`=1, the block raises `scan_done`, `scan_err` and `mbox_failed`, and issues no discovery request.
- R3: Every discovery request has `req_abort`=0, `req_vid`=`STD_VID` and `req_type`=0. `req_data[7:0]` holds the index and `req_data[31:8]` is zero. The first index after the abort is 0.
- R4: A good discovery reply carries the vendor ID in `rsp_data[15:0]`, the protocol in `[23:16]` and the next index in `[31:24]`. The pair is stored in the next free table slot, and `entry_count` rises by one.
- R5: The next request uses the returned next index. A reply whose next index is 0 ends the scan with `scan_done`=1 and `scan_err`=0.
- R6: A discovery reply with `rsp_err`=1 or with `rsp_len` other than 1 ends the scan with `scan_err`=1. Nothing is stored from that reply.
- R7: A reply that arrives when the table already holds `TBL_DEPTH` entries ends the scan with `scan_err`=1. A chain of exactly `TBL_DEPTH` entries finishes without error.
- R8: `lk_hit` is 1 for a pair held in a filled slot while `scan_err`=0. After an error, every pair other than discovery misses.
- R9: The pair (`STD_VID`, 0) always gives `lk_hit`=1.
- R10: Once `scan_done` is 1 it stays 1 until reset, and `req_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | output | 1 | Request to the mailbox requester |
| req_ready | input | 1 | Requester accepts the request |
| req_abort | output | 1 | 1 = abort request, 0 = data-object exchange |
| req_vid | output | 16 | Vendor ID of the exchange |
| req_type | output | 8 | Protocol type of the exchange |
| req_data | output | 32 | One-dword request payload |
| rsp_valid | input | 1 | Reply strobe, one cycle |
| rsp_err | input | 1 | Transport or abort failure |
| rsp_len | input | LEN_W | Reply payload length in dwords |
| rsp_data | input | 32 | First reply payload dword |
| lk_vid | input | 16 | Lookup vendor ID |
| lk_type | input | 8 | Lookup protocol type |
| lk_hit | output | 1 | Lookup pair is supported |
| scan_done | output | 1 | Scan has ended |
| scan_err | output | 1 | Scan ended with an error |
| mbox_failed | output | 1 | Abort failed; mailbox unusable |
| entry_count | output | CNT_W | Number of stored pairs |

## Verification
The assertions check properties that hold on every cycle:
- the discovery request encoding,
- a request holding while it is stalled,
- a sticky done flag with no further requests after it,
- the failed mailbox implying an error,
- the discovery pair always hitting,
- the lookup being masked after an error,
- the table count never passing its depth.

Only the bench scenarios can show the rest. These are the order in which the chain is followed, which slots receive which pairs, the boundary between a table that is exactly full and one that overflows, and the reaction to each kind of bad reply.

// File: rtl/pscan_pkg.sv
// Shared constants and state type for the protocol discovery scanner.
// Assumes the discovery dword layout: index [7:0] in requests;
// vendor ID [15:0], protocol [23:16], next index [31:24] in replies.
package pscan_pkg;
    localparam int VID_W  = 16;
    localparam int TYPE_W = 8;
    localparam int IDX_W  = 8;
    localparam int DW_W   = 32;

    typedef enum logic [2:0] {
        ST_ABORT_REQ,
        ST_ABORT_WAIT,
        ST_DISC_REQ,
        ST_DISC_WAIT,
        ST_DONE
    } scan_state_e;
endpackage

// File: rtl/pscan_table.sv
// Pair table: stores (vendor ID, protocol) pairs in consecutive slots and
// matches a lookup pair against every filled slot in parallel.
// Assumes wr_en is only raised while the table is not full.
module pscan_table
    import pscan_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [VID_W-1:0]  wr_vid,
    input  logic [TYPE_W-1:0] wr_type,
    input  logic [VID_W-1:0]  lk_vid,
    input  logic [TYPE_W-1:0] lk_type,
    output logic              hit,
    output logic              full,
    output logic [CNT_W-1:0]  count
);
    logic [DEPTH-1:0] match;

    assign full = (count == CNT_W'(DEPTH));
    assign hit  = |match;

    // Fill counter: advances on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (wr_en && !full)
            count <= count + 1'b1;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic              valid_q;
        logic [VID_W-1:0]  vid_q;
        logic [TYPE_W-1:0] type_q;

        // Slot g captures the pair written while count points at it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                vid_q   <= '0;
                type_q  <= '0;
            end else if (wr_en && !full && count == CNT_W'(g)) begin
                valid_q <= 1'b1;
                vid_q   <= wr_vid;
                type_q  <= wr_type;
            end
        end

        assign match[g] = valid_q && (vid_q == lk_vid) && (type_q == lk_type);
    end
endmodule

// File: rtl/pscan_fsm.sv
// Scan sequencer: issues the abort, then walks the discovery chain and
// decides for each reply whether to store, continue, finish or fail.
// Assumes rsp_valid is a one-cycle strobe arriving after request acceptance.
module pscan_fsm
    import pscan_pkg::*;
#(
    parameter int             LEN_W   = 18,
    parameter logic [15:0]    STD_VID = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_abort,
    output logic [VID_W-1:0]  req_vid,
    output logic [TYPE_W-1:0] req_type,
    output logic [DW_W-1:0]   req_data,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [LEN_W-1:0]  rsp_len,
    input  logic [DW_W-1:0]   rsp_data,
    input  logic              tbl_full,
    output logic              wr_en,
    output logic [VID_W-1:0]  wr_vid,
    output logic [TYPE_W-1:0] wr_type,
    output logic              done,
    output logic              err,
    output logic              failed
);
    scan_state_e      state;
    logic [IDX_W-1:0] idx_q;
    logic             rsp_good;
    logic [IDX_W-1:0] next_idx;

    assign next_idx  = rsp_data[31:24];
    assign rsp_good  = !rsp_err && (rsp_len == LEN_W'(1)) && !tbl_full;
    assign req_valid = (state == ST_ABORT_REQ) || (state == ST_DISC_REQ);
    assign req_abort = (state == ST_ABORT_REQ);
    assign req_vid   = req_abort ? '0 : STD_VID;
    assign req_type  = '0;
    assign req_data  = req_abort ? '0 : {{(DW_W-IDX_W){1'b0}}, idx_q};
    assign wr_en     = (state == ST_DISC_WAIT) && rsp_valid && rsp_good;
    assign wr_vid    = rsp_data[15:0];
    assign wr_type   = rsp_data[23:16];

    // Sequencer state, current index and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_ABORT_REQ;
            idx_q  <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            failed <= 1'b0;
        end else begin
            case (state)
                ST_ABORT_REQ:
                    if (req_ready) state <= ST_ABORT_WAIT;
                ST_ABORT_WAIT:
                    if (rsp_valid) begin
                        if (rsp_err) begin
                            failed <= 1'b1;
                            err    <= 1'b1;
                            done   <= 1'b1;
                            state  <= ST_DONE;
                        end else begin
                            idx_q <= '0;
                            state <= ST_DISC_REQ;
                        end
                    end
                ST_DISC_REQ:
                    if (req_ready) state <= ST_DISC_WAIT;
                ST_DISC_WAIT:
                    if (rsp_valid) begin
                        if (!rsp_good) begin
                            err   <= 1'b1;
                            done  <= 1'b1;
                            state <= ST_DONE;
                        end else if (next_idx == '0) begin
                            done  <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            idx_q <= next_idx;
                            state <= ST_DISC_REQ;
                        end
                    end
                default:
                    state <= ST_DONE;
            endcase
        end
    end
endmodule

// File: rtl/mbox_proto_scan.sv
// Top of the protocol discovery scanner: joins the sequencer and the pair
// table, and gates lookups (discovery always hits; others miss after error).
// Assumes one requester shared only with this block until scan_done.
module mbox_proto_scan
    import pscan_pkg::*;
#(
    parameter int          TBL_DEPTH = 4,
    parameter int          LEN_W     = 18,
    parameter logic [15:0] STD_VID   = 16'h0001,
    localparam int         CNT_W     = $clog2(TBL_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_abort,
    output logic [15:0]       req_vid,
    output logic [7:0]        req_type,
    output logic [31:0]       req_data,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [LEN_W-1:0]  rsp_len,
    input  logic [31:0]       rsp_data,
    input  logic [15:0]       lk_vid,
    input  logic [7:0]        lk_type,
    output logic              lk_hit,
    output logic              scan_done,
    output logic              scan_err,
    output logic              mbox_failed,
    output logic [CNT_W-1:0]  entry_count
);
    logic              wr_en;
    logic [VID_W-1:0]  wr_vid;
    logic [TYPE_W-1:0] wr_type;
    logic              tbl_hit;
    logic              tbl_full;
    logic              is_disc;

    pscan_fsm #(.LEN_W(LEN_W), .STD_VID(STD_VID)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_abort(req_abort),
        .req_vid(req_vid), .req_type(req_type), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_len(rsp_len),
        .rsp_data(rsp_data), .tbl_full(tbl_full),
        .wr_en(wr_en), .wr_vid(wr_vid), .wr_type(wr_type),
        .done(scan_done), .err(scan_err), .failed(mbox_failed)
    );

    pscan_table #(.DEPTH(TBL_DEPTH)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_vid(wr_vid), .wr_type(wr_type),
        .lk_vid(lk_vid), .lk_type(lk_type),
        .hit(tbl_hit), .full(tbl_full), .count(entry_count)
    );

    assign is_disc = (lk_vid == STD_VID) && (lk_type == '0);
    assign lk_hit  = is_disc || (tbl_hit && !scan_err);
endmodule

// File: rtl/pscan_chk.sv
// Assertion checker for mbox_proto_scan, attached by bind below.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module pscan_chk #(
    parameter int          TBL_DEPTH = 4,
    parameter int          LEN_W     = 18,
    parameter logic [15:0] STD_VID   = 16'h0001,
    localparam int         CNT_W     = $clog2(TBL_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_abort,
    input logic [15:0]       req_vid,
    input logic [7:0]        req_type,
    input logic [31:0]       req_data,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [LEN_W-1:0]  rsp_len,
    input logic              lk_hit,
    input logic [15:0]       lk_vid,
    input logic [7:0]        lk_type,
    input logic              scan_done,
    input logic              scan_err,
    input logic              mbox_failed,
    input logic [CNT_W-1:0]  entry_count
);
    // R3
    disc_req_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_abort) |-> (req_vid == STD_VID && req_type == 8'h00
                                       && req_data[31:8] == 24'h0));
    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_abort)
                                       && $stable(req_data)));
    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> scan_done);
    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !req_valid);
    // R2
    failed_implies_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_failed |-> (scan_err && scan_done));
    // R9
    disc_always_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vid == STD_VID && lk_type == 8'h00) |-> lk_hit);
    // R8
    err_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_err && !(lk_vid == STD_VID && lk_type == 8'h00)) |-> !lk_hit);
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= CNT_W'(TBL_DEPTH));
    // R6
    bad_rsp_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_err || rsp_len != LEN_W'(1))) |=> $stable(entry_count));
endmodule

bind mbox_proto_scan pscan_chk #(.TBL_DEPTH(TBL_DEPTH), .LEN_W(LEN_W), .STD_VID(STD_VID)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_abort(req_abort), .req_vid(req_vid), .req_type(req_type),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_len(rsp_len), .lk_hit(lk_hit), .lk_vid(lk_vid), .lk_type(lk_type),
    .scan_done(scan_done), .scan_err(scan_err), .mbox_failed(mbox_failed),
    .entry_count(entry_count)
);

// File: tb/tb_mbox_proto_scan.sv
module tb_mbox_proto_scan;
    localparam int DEPTH = 4;
    localparam int LEN_W = 18;
    localparam logic [15:0] SVID = 16'h0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid, req_abort;
    logic req_ready = 1'b1;
    logic [15:0] req_vid;
    logic [7:0]  req_type;
    logic [31:0] req_data;
    logic rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [LEN_W-1:0] rsp_len = '0;
    logic [31:0] rsp_data = '0;
    logic [15:0] lk_vid = '0;
    logic [7:0]  lk_type = 8'h55;
    logic lk_hit, scan_done, scan_err, mbox_failed;
    logic [2:0] entry_count;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mbox_proto_scan #(.TBL_DEPTH(DEPTH), .LEN_W(LEN_W), .STD_VID(SVID)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_abort(req_abort), .req_vid(req_vid), .req_type(req_type),
        .req_data(req_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_len(rsp_len), .rsp_data(rsp_data), .lk_vid(lk_vid),
        .lk_type(lk_type), .lk_hit(lk_hit), .scan_done(scan_done),
        .scan_err(scan_err), .mbox_failed(mbox_failed), .entry_count(entry_count)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rsp_valid = 1'b0; req_ready = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset done", {31'b0, scan_done}, 0);
        check("R1 reset err", {scan_err, mbox_failed}, 0);
        check("R1 reset count", {29'b0, entry_count}, 0);
        rst_n = 1'b1;
    endtask

    task automatic wait_req();
        for (int i = 0; i < 50 && !req_valid; i++) @(negedge clk);
    endtask

    task automatic serve_abort(bit ok);
        wait_req();
        check("R1 abort first", {req_valid, req_abort}, 2'b11);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_err = !ok; rsp_len = '0; rsp_data = '0;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
    endtask

    task automatic serve_disc(logic [7:0] idx, bit terr, int len,
                              logic [15:0] vid, logic [7:0] prot, logic [7:0] nxt);
        wait_req();
        check("R3 req kind", {req_valid, req_abort}, 2'b10);
        check("R3 req vid/type", {req_vid, req_type}, {SVID, 8'h00});
        check("R3/R5 req index", req_data, {24'h0, idx});
        @(negedge clk);
        rsp_valid = 1'b1; rsp_err = terr; rsp_len = LEN_W'(len);
        rsp_data = {nxt, prot, vid};
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
    endtask

    task automatic lookup(logic [15:0] v, logic [7:0] t, bit exp, string req);
        lk_vid = v; lk_type = t;
        #1;
        check(req, {31'b0, lk_hit}, {31'b0, exp});
    endtask

    task automatic t_chain();
        do_reset();
        req_ready = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 held abort", {req_valid, req_abort}, 2'b11);
        req_ready = 1'b1;
        serve_abort(1);
        serve_disc(8'd0, 0, 1, 16'h1E0F, 8'h02, 8'd3);
        check("R4 count 1", {29'b0, entry_count}, 1);
        serve_disc(8'd3, 0, 1, 16'hABCD, 8'h07, 8'd9);
        serve_disc(8'd9, 0, 1, 16'h2222, 8'h11, 8'd0);
        check("R5 done ok", {scan_done, scan_err, mbox_failed}, 3'b100);
        check("R4 count 3", {29'b0, entry_count}, 3);
        lookup(16'h1E0F, 8'h02, 1, "R8 hit slot0");
        lookup(16'hABCD, 8'h07, 1, "R8 hit slot1");
        lookup(16'h2222, 8'h11, 1, "R8 hit slot2");
        lookup(16'hABCD, 8'h02, 0, "R8 miss mixed pair");
        lookup(SVID, 8'h00, 1, "R9 discovery hit");
        repeat (4) @(negedge clk);
        check("R10 done quiet", {scan_done, req_valid}, 2'b10);
    endtask

    task automatic t_abort_fail();
        do_reset();
        serve_abort(0);
        check("R2 failed flags", {scan_done, scan_err, mbox_failed}, 3'b111);
        repeat (5) @(negedge clk);
        check("R2 no discovery", {31'b0, req_valid}, 0);
        lookup(SVID, 8'h00, 1, "R9 discovery after fail");
    endtask

    task automatic t_bad_len();
        do_reset();
        serve_abort(1);
        serve_disc(8'd0, 0, 1, 16'h3333, 8'h01, 8'd1);
        serve_disc(8'd1, 0, 2, 16'h4444, 8'h02, 8'd0);
        check("R6 len err", {scan_done, scan_err, mbox_failed}, 3'b110);
        check("R6 nothing stored", {29'b0, entry_count}, 1);
        lookup(16'h3333, 8'h01, 0, "R8 masked after err");
        lookup(SVID, 8'h00, 1, "R9 discovery after err");
    endtask

    task automatic t_transport_err();
        do_reset();
        serve_abort(1);
        serve_disc(8'd0, 1, 1, 16'h5555, 8'h03, 8'd0);
        check("R6 transport err", {scan_done, scan_err}, 2'b11);
        check("R6 count 0", {29'b0, entry_count}, 0);
    endtask

    task automatic t_exact_full();
        do_reset();
        serve_abort(1);
        for (int i = 0; i < DEPTH; i++)
            serve_disc(8'(i), 0, 1, 16'h0100 + 16'(i), 8'(i + 1),
                       (i == DEPTH - 1) ? 8'd0 : 8'(i + 1));
        check("R7 exact full ok", {scan_done, scan_err}, 2'b10);
        check("R7 count depth", {29'b0, entry_count}, DEPTH);
        lookup(16'h0103, 8'h04, 1, "R8 last slot hit");
    endtask

    task automatic t_overflow();
        do_reset();
        serve_abort(1);
        for (int i = 0; i < DEPTH; i++)
            serve_disc(8'(i), 0, 1, 16'h0200 + 16'(i), 8'(i + 1), 8'(i + 1));
        serve_disc(8'(DEPTH), 0, 1, 16'h0999, 8'h09, 8'd0);
        check("R7 overflow err", {scan_done, scan_err}, 2'b11);
        check("R7 count held", {29'b0, entry_count}, DEPTH);
        lookup(16'h0200, 8'h01, 0, "R8 masked after overflow");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_chain();
        t_abort_fail();
        t_bad_len();
        t_transport_err();
        t_exact_full();
        t_overflow();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule